// File: doc/BRIEF.md
# Sideband Client Power-Up Response Gate

This block sits in front of a sideband management client and decides, for every incoming request, how the client is allowed to answer while the chip powers up and leaves reset. It follows the power-good level, the monitored active-low chip reset and a core-ready flag through a sequence of phases. In each phase every command class is either served normally, answered with a substitute temperature of zero, refused with the response-timeout completion code, or ignored, in which case the reply is all zeroes.

A fatal-error flag reopens every non-core service while the client is still in its not-ready phase, so configuration space can be read for debug after a crash. Both power-up delays are parameters counted in clock cycles. Wire-level signalling, frame checks and the register spaces behind the services belong to other blocks; this gate only produces a one-cycle response strobe with an outcome code and a completion code, and shows the current phase.

Top module: `pwr_resp_gate`

## Requirements
- R1: While power-good is low, or while the phase is off (0) or booting (1), every request is answered with outcome 3 (all-zero) and completion code 0x00.
- R2: After power-good is first sampled high in the off phase, the phase changes to booting (1) on that edge and to not-ready (2) exactly BOOT_CYCLES edges later.
- R3: In the not-ready phase without a fatal error, ping (class 0) and identity (class 1) requests get outcome 0 (normal) with completion code 0x40.
- R4: In the not-ready phase without a fatal error, a temperature request (class 2) gets outcome 1 (substitute temperature 0x0000) with completion code 0x40.
- R5: In the not-ready phase without a fatal error, classes 3, 4, 5, 6 and 7 get outcome 2 (timeout) with completion code 0x81; outcome 2 always carries 0x81.
- R6: The chip-reset counter runs only while the monitored reset is high, restarts whenever it goes low, and moves not-ready to partial (3) on the edge after RESET_CYCLES counted edges.
- R7: In the partial phase, core register requests (class 5) get outcome 2 with 0x81 and every other class gets outcome 0 with 0x40.
- R8: In the partial phase, a high core-ready flag moves the phase to full (4) on the next edge; in full, every class gets outcome 0 with 0x40, and full is reached only from partial.
- R9: In the not-ready phase with the fatal-error flag high, every class except 5 gets outcome 0 with 0x40, and class 5 gets outcome 2 with 0x81.
- R10: Power-good low returns the phase to off on the next edge and clears both counters, so a new power-up takes the full boot delay again; the block reset also leaves the phase off.
- R11: Each request produces exactly one response strobe, on the edge after the request is sampled, and no strobe appears without a request.
- R12: With power-good high, the monitored reset going low in the partial or full phase moves the phase back to not-ready on the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| sysRstN | input | 1 | Asynchronous active-low reset of the block itself |
| pwrGood | input | 1 | Power-good level of the managed chip |
| cpuRstN | input | 1 | Monitored active-low chip reset |
| coreReady | input | 1 | High once the cores have left reset |
| fatalErr | input | 1 | Fatal or catastrophic error flag |
| reqValid | input | 1 | One-cycle request strobe |
| reqClass | input | 3 | Decoded command class (0 ping, 1 identity, 2 temperature, 3 package read, 4 package write, 5 core register, 6 config space, 7 other) |
| rspValid | output | 1 | Response strobe, one cycle after the request |
| rspOutcome | output | 2 | 0 normal, 1 substitute temperature, 2 timeout, 3 all-zero |
| rspCode | output | 8 | Completion code for the response |
| phase | output | 3 | 0 off, 1 booting, 2 not-ready, 3 partial, 4 full |

## Verification
On every cycle the assertions hold the strobe pairing between requests and responses, the fixed code carried by timeout and all-zero outcomes, the refusal of core register access outside the full phase, and the legal phase steps on power loss, reset reassertion and entry into full. Exact delay lengths, the restart of the reset counter after a short pulse, the per-class answers in each phase and the early reopening under a fatal error are shown only by the bench's scenarios, which walk the block through a complete power-up, a reset bounce and a power loss with a second power-up.

// File: rtl/pwrgate_pkg.sv
package pwrgate_pkg;

  typedef enum logic [2:0] {
    PH_OFF      = 3'd0,
    PH_BOOT     = 3'd1,
    PH_NOTREADY = 3'd2,
    PH_PARTIAL  = 3'd3,
    PH_FULL     = 3'd4
  } phase_e;

  typedef enum logic [2:0] {
    CMD_PING     = 3'd0,
    CMD_IDENT    = 3'd1,
    CMD_TEMP     = 3'd2,
    CMD_PKG_RD   = 3'd3,
    CMD_PKG_WR   = 3'd4,
    CMD_CORE_REG = 3'd5,
    CMD_CFG      = 3'd6,
    CMD_OTHER    = 3'd7
  } cmd_e;

  typedef enum logic [1:0] {
    OUT_NORMAL  = 2'd0,
    OUT_TEMP    = 2'd1,
    OUT_TIMEOUT = 2'd2,
    OUT_ZERO    = 2'd3
  } outcome_e;

  // strobes from the phase control to the response datapath
  typedef struct packed {
    logic zeroAll;     // no service at all, reply is all zero
    logic limited;     // only ping, identity and substitute temperature
    logic coreLocked;  // core register access refused
  } gate_t;

  localparam logic [7:0] CC_OK      = 8'h40;
  localparam logic [7:0] CC_TIMEOUT = 8'h81;
  localparam logic [7:0] CC_NONE    = 8'h00;

endpackage

// File: rtl/pwrgate_ctrl.sv
module pwrgate_ctrl
  import pwrgate_pkg::*;
#(
  parameter int BOOT_CYCLES  = 5000,
  parameter int RESET_CYCLES = 25000
) (
  input  logic   clk,
  input  logic   sysRstN,
  input  logic   pwrGood,
  input  logic   cpuRstN,
  input  logic   coreReady,
  input  logic   fatalErr,
  output gate_t  gate,
  output phase_e phaseQ
);

  localparam int BOOT_W  = $clog2(BOOT_CYCLES + 1);
  localparam int RESET_W = $clog2(RESET_CYCLES + 1);
  localparam logic [BOOT_W-1:0]  BOOT_LAST  = BOOT_W'(BOOT_CYCLES - 1);
  localparam logic [RESET_W-1:0] RESET_DONE = RESET_W'(RESET_CYCLES);

  logic [BOOT_W-1:0]  bootCnt;
  logic [RESET_W-1:0] rstCnt;
  logic               rstCounting;
  logic               rstElapsed;

  assign rstCounting = cpuRstN && (phaseQ == PH_BOOT || phaseQ == PH_NOTREADY)
                       && (rstCnt != RESET_DONE);
  assign rstElapsed  = cpuRstN && (rstCnt == RESET_DONE);

  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN) begin
      phaseQ  <= PH_OFF;
      bootCnt <= '0;
      rstCnt  <= '0;
    end else if (!pwrGood) begin
      // R10: power loss clears everything
      phaseQ  <= PH_OFF;
      bootCnt <= '0;
      rstCnt  <= '0;
    end else begin
      // R6: chip-reset window restarts on every reset assertion
      if (!cpuRstN) begin
        rstCnt <= '0;
      end else if (rstCounting) begin
        rstCnt <= rstCnt + 1'b1;
      end

      unique case (phaseQ)
        PH_OFF: begin
          phaseQ  <= PH_BOOT;
          bootCnt <= '0;
        end
        PH_BOOT: begin
          if (bootCnt == BOOT_LAST) phaseQ <= PH_NOTREADY;
          else                      bootCnt <= bootCnt + 1'b1;
        end
        PH_NOTREADY: begin
          if (rstElapsed) phaseQ <= PH_PARTIAL;
        end
        PH_PARTIAL: begin
          if (!cpuRstN)       phaseQ <= PH_NOTREADY;
          else if (coreReady) phaseQ <= PH_FULL;
        end
        PH_FULL: begin
          if (!cpuRstN) phaseQ <= PH_NOTREADY;
        end
        default: phaseQ <= PH_OFF;
      endcase
    end
  end

  always_comb begin
    gate.zeroAll    = !pwrGood || phaseQ == PH_OFF || phaseQ == PH_BOOT;
    gate.limited    = (phaseQ == PH_NOTREADY) && !fatalErr;
    gate.coreLocked = (phaseQ == PH_NOTREADY) || (phaseQ == PH_PARTIAL);
  end

endmodule

// File: rtl/pwrgate_dp.sv
module pwrgate_dp
  import pwrgate_pkg::*;
(
  input  logic       clk,
  input  logic       sysRstN,
  input  gate_t      gate,
  input  logic       reqValid,
  input  logic [2:0] reqClass,
  output logic       rspValid,
  output logic [1:0] rspOutcome,
  output logic [7:0] rspCode
);

  cmd_e       cls;
  outcome_e   nextOut;
  logic [7:0] nextCode;

  assign cls = cmd_e'(reqClass);

  always_comb begin
    nextOut = OUT_NORMAL;
    if (gate.zeroAll) begin
      nextOut = OUT_ZERO;
    end else if (cls == CMD_CORE_REG && gate.coreLocked) begin
      nextOut = OUT_TIMEOUT;
    end else if (gate.limited) begin
      unique case (cls)
        CMD_PING, CMD_IDENT: nextOut = OUT_NORMAL;
        CMD_TEMP:            nextOut = OUT_TEMP;
        default:             nextOut = OUT_TIMEOUT;
      endcase
    end
  end

  always_comb begin
    unique case (nextOut)
      OUT_NORMAL, OUT_TEMP: nextCode = CC_OK;
      OUT_TIMEOUT:          nextCode = CC_TIMEOUT;
      default:              nextCode = CC_NONE;
    endcase
  end

  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN) begin
      rspValid   <= 1'b0;
      rspOutcome <= OUT_ZERO;
      rspCode    <= CC_NONE;
    end else begin
      rspValid <= reqValid;
      if (reqValid) begin
        rspOutcome <= nextOut;
        rspCode    <= nextCode;
      end
    end
  end

endmodule

// File: rtl/pwr_resp_gate.sv
module pwr_resp_gate
  import pwrgate_pkg::*;
#(
  parameter int BOOT_CYCLES  = 5000,
  parameter int RESET_CYCLES = 25000
) (
  input  logic       clk,
  input  logic       sysRstN,
  input  logic       pwrGood,
  input  logic       cpuRstN,
  input  logic       coreReady,
  input  logic       fatalErr,
  input  logic       reqValid,
  input  logic [2:0] reqClass,
  output logic       rspValid,
  output logic [1:0] rspOutcome,
  output logic [7:0] rspCode,
  output logic [2:0] phase
);

  gate_t  gate;
  phase_e phaseQ;

  pwrgate_ctrl #(
    .BOOT_CYCLES (BOOT_CYCLES),
    .RESET_CYCLES(RESET_CYCLES)
  ) ctrl_i (
    .clk      (clk),
    .sysRstN  (sysRstN),
    .pwrGood  (pwrGood),
    .cpuRstN  (cpuRstN),
    .coreReady(coreReady),
    .fatalErr (fatalErr),
    .gate     (gate),
    .phaseQ   (phaseQ)
  );

  pwrgate_dp dp_i (
    .clk       (clk),
    .sysRstN   (sysRstN),
    .gate      (gate),
    .reqValid  (reqValid),
    .reqClass  (reqClass),
    .rspValid  (rspValid),
    .rspOutcome(rspOutcome),
    .rspCode   (rspCode)
  );

  assign phase = phaseQ;

endmodule

// File: rtl/pwrgate_chk.sv
module pwrgate_chk
  import pwrgate_pkg::*;
(
  input logic       clk,
  input logic       sysRstN,
  input logic       pwrGood,
  input logic       cpuRstN,
  input logic       reqValid,
  input logic [2:0] reqClass,
  input logic       rspValid,
  input logic [1:0] rspOutcome,
  input logic [7:0] rspCode,
  input logic [2:0] phase
);

  // R11
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!sysRstN)
    reqValid |=> rspValid);

  // R11
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!sysRstN)
    rspValid |-> $past(reqValid));

  // R10
  power_loss_off_chk: assert property (@(posedge clk) disable iff (!sysRstN)
    !pwrGood |=> phase == PH_OFF);

  // R1
  unpowered_zero_chk: assert property (@(posedge clk) disable iff (!sysRstN)
    (rspValid && $past(!pwrGood)) |-> (rspOutcome == OUT_ZERO && rspCode == CC_NONE));

  // R5
  timeout_code_chk: assert property (@(posedge clk) disable iff (!sysRstN)
    (rspValid && rspOutcome == OUT_TIMEOUT) |-> rspCode == CC_TIMEOUT);

  // R7
  core_locked_chk: assert property (@(posedge clk) disable iff (!sysRstN)
    (rspValid && $past(reqClass) == CMD_CORE_REG && $past(phase) != PH_FULL)
      |-> rspOutcome != OUT_NORMAL);

  // R4
  temp_sub_only_notready_chk: assert property (@(posedge clk) disable iff (!sysRstN)
    (rspValid && rspOutcome == OUT_TEMP) |-> $past(phase) == PH_NOTREADY);

  // R8
  full_from_partial_chk: assert property (@(posedge clk) disable iff (!sysRstN)
    phase == PH_FULL |-> ($past(phase) == PH_PARTIAL || $past(phase) == PH_FULL));

  // R12
  reset_reassert_chk: assert property (@(posedge clk) disable iff (!sysRstN)
    ((phase == PH_PARTIAL || phase == PH_FULL) && !cpuRstN && pwrGood)
      |=> phase == PH_NOTREADY);

endmodule

bind pwr_resp_gate pwrgate_chk chk_i (
  .clk       (clk),
  .sysRstN   (sysRstN),
  .pwrGood   (pwrGood),
  .cpuRstN   (cpuRstN),
  .reqValid  (reqValid),
  .reqClass  (reqClass),
  .rspValid  (rspValid),
  .rspOutcome(rspOutcome),
  .rspCode   (rspCode),
  .phase     (phase)
);

// File: tb/pwr_resp_gate_tb.sv
`timescale 1ns/1ps
module pwr_resp_gate_tb_top;

  localparam int BOOT_N  = 8;
  localparam int RESET_N = 12;

  logic       clk = 1'b0;
  logic       sysRstN, pwrGood, cpuRstN, coreReady, fatalErr, reqValid;
  logic [2:0] reqClass;
  logic       rspValid;
  logic [1:0] rspOutcome;
  logic [7:0] rspCode;
  logic [2:0] phase;

  int  total = 0;
  int  bad = 0;
  int  cycleCnt = 0;
  bit  finished = 1'b0;

  logic [1:0] expOutQ[$];
  logic [7:0] expCodeQ[$];
  string      expTagQ[$];

  always #10 clk = ~clk;
  always @(posedge clk) cycleCnt <= cycleCnt + 1;

  pwr_resp_gate #(.BOOT_CYCLES(BOOT_N), .RESET_CYCLES(RESET_N)) dut_i (
    .clk(clk), .sysRstN(sysRstN), .pwrGood(pwrGood), .cpuRstN(cpuRstN),
    .coreReady(coreReady), .fatalErr(fatalErr), .reqValid(reqValid),
    .reqClass(reqClass), .rspValid(rspValid), .rspOutcome(rspOutcome),
    .rspCode(rspCode), .phase(phase)
  );

  task automatic check(bit ok, string tag, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  // driver: one request, expected answer goes to the scoreboard
  task automatic sendReq(int cls, logic [1:0] eo, logic [7:0] ec, string tag);
    tick();
    reqValid = 1'b1;
    reqClass = 3'(cls);
    expOutQ.push_back(eo);
    expCodeQ.push_back(ec);
    expTagQ.push_back(tag);
    tick();
    reqValid = 1'b0;
  endtask

  task automatic checkPhase(int exp, string tag);
    @(negedge clk);
    check(phase == 3'(exp), tag, "phase", int'(phase), exp);
  endtask

  task automatic waitPhase(int exp, int start, int expEdges, string tag);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (phase == 3'(exp)) break;
    end
    check(phase == 3'(exp), tag, "phase reached", int'(phase), exp);
    check(cycleCnt - start == expEdges, tag, "edges to phase", cycleCnt - start, expEdges);
  endtask

  // monitor: pops one expected item per response strobe
  always @(negedge clk) begin
    if (!finished && sysRstN) begin
      if (rspValid && expOutQ.size() == 0) begin
        check(1'b0, "R11", "unexpected response", 1, 0);
      end else if (!rspValid && expOutQ.size() != 0) begin
        check(1'b0, "R11", "missing response", 0, 1);
        void'(expOutQ.pop_front());
        void'(expCodeQ.pop_front());
        void'(expTagQ.pop_front());
      end else if (rspValid) begin
        logic [1:0] eo;
        logic [7:0] ec;
        string tg;
        eo = expOutQ.pop_front();
        ec = expCodeQ.pop_front();
        tg = expTagQ.pop_front();
        check(rspOutcome == eo, tg, "outcome", int'(rspOutcome), int'(eo));
        check(rspCode == ec, tg, "code", int'(rspCode), int'(ec));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int start;
    sysRstN = 1'b0; pwrGood = 1'b0; cpuRstN = 1'b0; coreReady = 1'b0;
    fatalErr = 1'b0; reqValid = 1'b0; reqClass = 3'd0;
    repeat (3) @(negedge clk);
    // R10: reset state
    check(phase == 3'd0, "R10", "reset phase", int'(phase), 0);
    check(rspValid == 1'b0, "R11", "reset strobe", int'(rspValid), 0);
    tick();
    sysRstN = 1'b1;

    // R1: unpowered
    sendReq(0, 2'd3, 8'h00, "R1");
    sendReq(5, 2'd3, 8'h00, "R1");
    checkPhase(0, "R1");

    // R2: boot delay
    tick();
    pwrGood = 1'b1;
    start = cycleCnt;
    @(negedge clk);
    check(phase == 3'd1, "R2", "booting phase", int'(phase), 1);
    sendReq(2, 2'd3, 8'h00, "R1");
    waitPhase(2, start, BOOT_N + 1, "R2");

    // not-ready answers
    sendReq(0, 2'd0, 8'h40, "R3");
    sendReq(1, 2'd0, 8'h40, "R3");
    sendReq(2, 2'd1, 8'h40, "R4");
    for (int c = 3; c < 8; c++) sendReq(c, 2'd2, 8'h81, "R5");

    // R9: fatal error reopens non-core services
    tick();
    fatalErr = 1'b1;
    sendReq(6, 2'd0, 8'h40, "R9");
    sendReq(3, 2'd0, 8'h40, "R9");
    sendReq(2, 2'd0, 8'h40, "R9");
    sendReq(5, 2'd2, 8'h81, "R9");
    tick();
    fatalErr = 1'b0;

    // R6: short reset release, then reassert restarts the window
    cpuRstN = 1'b1;
    repeat (5) tick();
    cpuRstN = 1'b0;
    repeat (2) tick();
    check(phase == 3'd2, "R6", "still not-ready", int'(phase), 2);
    cpuRstN = 1'b1;
    start = cycleCnt;
    waitPhase(3, start, RESET_N + 1, "R6");

    // R7: partial phase
    sendReq(3, 2'd0, 8'h40, "R7");
    sendReq(6, 2'd0, 8'h40, "R7");
    sendReq(2, 2'd0, 8'h40, "R7");
    sendReq(5, 2'd2, 8'h81, "R7");

    // R8: core ready
    tick();
    coreReady = 1'b1;
    checkPhase(4, "R8");
    sendReq(5, 2'd0, 8'h40, "R8");
    sendReq(2, 2'd0, 8'h40, "R8");
    sendReq(0, 2'd0, 8'h40, "R8");

    // R12: reset reasserted in full
    tick();
    cpuRstN = 1'b0;
    coreReady = 1'b0;
    checkPhase(2, "R12");
    sendReq(5, 2'd2, 8'h81, "R12");
    sendReq(2, 2'd1, 8'h40, "R12");

    // back to partial, then power loss with a request on that edge
    tick();
    cpuRstN = 1'b1;
    start = cycleCnt;
    waitPhase(3, start, RESET_N + 1, "R6");
    tick();
    pwrGood = 1'b0;
    reqValid = 1'b1;
    reqClass = 3'd0;
    expOutQ.push_back(2'd3);
    expCodeQ.push_back(8'h00);
    expTagQ.push_back("R1");
    tick();
    reqValid = 1'b0;
    check(phase == 3'd0, "R10", "off after power loss", int'(phase), 0);

    // R10: new power-up takes the full boot delay again
    tick();
    pwrGood = 1'b1;
    start = cycleCnt;
    waitPhase(2, start, BOOT_N + 1, "R10");

    repeat (3) @(negedge clk);
    check(expOutQ.size() == 0, "R11", "pending responses", expOutQ.size(), 0);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule